// File: doc/BRIEF.md
# Angular Intra Reference Sample Selector

This block serves one angular intra prediction equation per cycle. From the prediction mode, the signed prediction angle, the row or column index of the sample being predicted, and the block size code, it assembles a main reference array from the above and left neighbour samples. It then works out an integer offset and a 1/32 fractional phase for that position and hands out the four adjacent reference samples that a 4-tap interpolation filter needs. Entries that would fall outside the array are replaced by the nearest edge sample.

Alongside the four taps it returns a filter index. The index encodes both the filter family and the phase, so a downstream filter stage can pick its coefficient set directly. The block size decides the family: small blocks use the sharp cubic set and larger blocks use the smoother gaussian set. All selection is combinational and feeds one output register stage with a valid flag, so a new sample position can be accepted on every clock.

The main reference array has `NREF` entries, numbered 0 upward. The primary side is the side that the mode selects, and the other side is the opposite one.

Top module: `ira_ref_selector`

## Requirements
- R1: When the angle is zero or positive, the primary side is the above neighbours for mode_i >= 34 and the left neighbours for mode_i < 34. Main entry j equals primary sample j, and the base position equals the integer offset.
- R2: When the angle is negative, main entries 0..3 equal other-side samples 3,2,1,0 in that order. Main entry 4+k equals primary sample k, and the base position equals the integer offset plus 4.
- R3: The integer offset is floor(((idx_i+1)*angle)/32), computed as an arithmetic right shift by 5 of the sign-extended product. The phase is the product AND 31, and angle_i is a two's-complement value from -32 to +32.
- R4: The tap position is the base position clamped into [0, NREF-2]. p1_o is main entry pos and p2_o is main entry pos+1.
- R5: p0_o is main entry pos-1. When pos is 0, p0_o equals p1_o instead.
- R6: p3_o is main entry pos+2. When pos is NREF-2, p3_o equals p2_o instead.
- R7: The filter index within a family is (phase+1)>>1, giving 0..16. For size_i codes 0 (4x4) and 1 (8x8), filt_o is that value (cubic family). For codes 2 (16x16) and 3 (32x32), filt_o is 17 plus that value (gaussian family).
- R8: Outputs are registered with one cycle of latency. valid_o follows valid_i by one cycle, and the data outputs hold their value while valid_i is low. A synchronous active-low reset clears valid_o and all data outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | A new sample position is presented |
| mode_i | input | 7 | Angular prediction mode number |
| angle_i | input | ANG_W (7) | Signed prediction angle, two's complement |
| idx_i | input | IDX_W (5) | Row or column index of the predicted sample |
| size_i | input | 2 | Block size code: 0=4x4, 1=8x8, 2=16x16, 3=32x32 |
| above_i | input | NREF*SW | Above neighbours, sample k in bits [k*SW +: SW] |
| left_i | input | NREF*SW | Left neighbours, sample k in bits [k*SW +: SW] |
| valid_o | output | 1 | Registered outputs hold a new result |
| p0_o | output | SW | Tap before p1 |
| p1_o | output | SW | Tap at the offset position |
| p2_o | output | SW | Tap after p1 |
| p3_o | output | SW | Tap after p2 |
| filt_o | output | 6 | Filter index: family and phase |

## Verification
A wrong side choice, a misplaced splice or an off-by-one in the offset shows up as a tap value from the wrong neighbour or the wrong entry. The neighbour values are all distinct, so any such error appears on p0_o..p3_o in the cycle after the position is presented. A bad floor on negative products shows up only for negative angles whose product is not a multiple of 32. Such cases are caught in the sweep because every angle from -32 to +32 is crossed with every index. Errors in edge replication or clamping appear only at the two ends of the array, so the sweep is set up to reach both ends. A wrong family or phase rounding shows at once as a filter index outside the expected half of 0..33.

// File: rtl/ira_pkg.sv
// Shared constants and helpers for the angular reference selector.
// Assumes block size codes 0..3 map to 4x4..32x32.
package ira_pkg;
    localparam int unsigned FRAC_BITS  = 5;
    localparam int unsigned FAM_SPAN   = 17;
    localparam int unsigned SPLICE_LEN = 4;
    localparam int unsigned FILT_W     = 6;

    typedef enum logic [1:0] {
        SZ_4  = 2'd0,
        SZ_8  = 2'd1,
        SZ_16 = 2'd2,
        SZ_32 = 2'd3
    } blk_size_e;

    // True when the block size selects the smoothing filter family.
    function automatic logic size_is_smooth(input logic [1:0] sz);
        return (sz == SZ_16) || (sz == SZ_32);
    endfunction
endpackage

// File: rtl/ira_offset_calc.sv
// Derives the integer offset and 1/32 phase for one sample position.
// Assumes idx is unsigned and angle is two's complement; the product is
// sign-extended so the shift floors toward minus infinity.
module ira_offset_calc #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned ANG_W = 7,
    localparam int unsigned PROD_W = IDX_W + 1 + ANG_W,
    localparam int unsigned OFF_W  = PROD_W - ira_pkg::FRAC_BITS
) (
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [ANG_W-1:0]        angle_i,
    output logic signed [OFF_W-1:0] off_o,
    output logic [ira_pkg::FRAC_BITS-1:0] phase_o,
    output logic                    neg_o
);
    logic [IDX_W:0]             step;
    logic signed [PROD_W-1:0]   step_x;
    logic signed [PROD_W-1:0]   angle_x;
    logic signed [PROD_W-1:0]   prod;

    // Form (idx+1)*angle with full sign extension and split it.
    always_comb begin
        step    = {1'b0, idx_i} + {{IDX_W{1'b0}}, 1'b1};
        step_x  = {{(PROD_W-IDX_W-1){1'b0}}, step};
        angle_x = {{(PROD_W-ANG_W){angle_i[ANG_W-1]}}, angle_i};
        prod    = step_x * angle_x;
        off_o   = prod[PROD_W-1:ira_pkg::FRAC_BITS];
        phase_o = prod[ira_pkg::FRAC_BITS-1:0];
        neg_o   = angle_i[ANG_W-1];
    end
endmodule

// File: rtl/ira_ref_builder.sv
// Assembles the main reference array from the above and left neighbours.
// Assumes both neighbour arrays hold NREF samples; with a negative angle the
// last four primary samples drop off the end to make room for the splice.
module ira_ref_builder #(
    parameter int unsigned SW   = 8,
    parameter int unsigned NREF = 64
) (
    input  logic [NREF*SW-1:0] above_i,
    input  logic [NREF*SW-1:0] left_i,
    input  logic               use_above_i,
    input  logic               neg_i,
    output logic [NREF*SW-1:0] main_o
);
    localparam int unsigned SPL = ira_pkg::SPLICE_LEN;

    logic [NREF*SW-1:0] prim;
    logic [NREF*SW-1:0] other;

    // Pick the primary and opposite neighbour sides from the mode.
    always_comb begin
        prim  = use_above_i ? above_i : left_i;
        other = use_above_i ? left_i  : above_i;
    end

    // One selector per main entry: spliced head, shifted body, or direct.
    for (genvar j = 0; j < NREF; j++) begin : g_entry
        if (j < SPL) begin : g_head
            always_comb
                main_o[j*SW +: SW] = neg_i ? other[(SPL-1-j)*SW +: SW]
                                           : prim[j*SW +: SW];
        end else begin : g_body
            always_comb
                main_o[j*SW +: SW] = neg_i ? prim[(j-SPL)*SW +: SW]
                                           : prim[j*SW +: SW];
        end
    end
endmodule

// File: rtl/ira_tap_pick.sv
// Clamps the tap position and reads four adjacent main-array entries,
// replicating the edge sample at either end of the array.
// Assumes NREF >= 3.
module ira_tap_pick #(
    parameter int unsigned SW    = 8,
    parameter int unsigned NREF  = 64,
    parameter int unsigned OFF_W = 8,
    localparam int unsigned POS_W = $clog2(NREF)
) (
    input  logic [NREF*SW-1:0]      main_i,
    input  logic signed [OFF_W-1:0] off_i,
    input  logic                    neg_i,
    output logic [POS_W-1:0]        pos_o,
    output logic [SW-1:0]           p0_o,
    output logic [SW-1:0]           p1_o,
    output logic [SW-1:0]           p2_o,
    output logic [SW-1:0]           p3_o
);
    localparam int unsigned RAW_W = OFF_W + 1;
    localparam logic signed [RAW_W-1:0] POS_MAX = RAW_W'(NREF - 2);

    logic signed [RAW_W-1:0] raw;
    logic [POS_W-1:0] pos_m1;
    logic [POS_W-1:0] pos_p1;
    logic [POS_W-1:0] pos_p2;

    // Add the splice bias and saturate into the legal range.
    always_comb begin
        raw = {off_i[OFF_W-1], off_i} + (neg_i ? RAW_W'(ira_pkg::SPLICE_LEN) : '0);
        if (raw < 0)
            pos_o = '0;
        else if (raw > POS_MAX)
            pos_o = POS_W'(NREF - 2);
        else
            pos_o = raw[POS_W-1:0];
    end

    // Read the four taps, replicating at both array ends.
    always_comb begin
        pos_m1 = pos_o - 1'b1;
        pos_p1 = pos_o + 1'b1;
        pos_p2 = pos_o + POS_W'(2);
        p1_o = main_i[pos_o*SW +: SW];
        p2_o = main_i[pos_p1*SW +: SW];
        p0_o = (pos_o == '0) ? p1_o : main_i[pos_m1*SW +: SW];
        p3_o = (pos_o == POS_W'(NREF - 2)) ? p2_o : main_i[pos_p2*SW +: SW];
    end
endmodule

// File: rtl/ira_ref_selector.sv
// Top: selects four reference taps and a filter index for one angular
// prediction position per cycle, with one registered output stage.
// Assumes mode, angle and size are consistent; out-of-reach positions clamp.
module ira_ref_selector #(
    parameter int unsigned SW         = 8,
    parameter int unsigned NREF       = 64,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned ANG_W      = 7,
    parameter int unsigned MODE_SPLIT = 34
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic [6:0]            mode_i,
    input  logic [ANG_W-1:0]      angle_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [1:0]            size_i,
    input  logic [NREF*SW-1:0]    above_i,
    input  logic [NREF*SW-1:0]    left_i,
    output logic                  valid_o,
    output logic [SW-1:0]         p0_o,
    output logic [SW-1:0]         p1_o,
    output logic [SW-1:0]         p2_o,
    output logic [SW-1:0]         p3_o,
    output logic [ira_pkg::FILT_W-1:0] filt_o
);
    import ira_pkg::*;

    localparam int unsigned OFF_W = IDX_W + 1 + ANG_W - FRAC_BITS;
    localparam int unsigned POS_W = $clog2(NREF);

    logic signed [OFF_W-1:0] off;
    logic [FRAC_BITS-1:0]    phase;
    logic                    neg;
    logic                    use_above;
    logic [NREF*SW-1:0]      main_arr;
    logic [POS_W-1:0]        pos;
    logic [SW-1:0]           t0, t1, t2, t3;
    logic [FILT_W-1:0]       fsel;
    logic [FILT_W-1:0]       filt_nxt;

    ira_offset_calc #(.IDX_W(IDX_W), .ANG_W(ANG_W)) u_off (
        .idx_i(idx_i), .angle_i(angle_i),
        .off_o(off), .phase_o(phase), .neg_o(neg)
    );

    // Mode decides which neighbour side feeds the main array.
    always_comb use_above = (mode_i >= 7'(MODE_SPLIT));

    ira_ref_builder #(.SW(SW), .NREF(NREF)) u_ref (
        .above_i(above_i), .left_i(left_i),
        .use_above_i(use_above), .neg_i(neg), .main_o(main_arr)
    );

    ira_tap_pick #(.SW(SW), .NREF(NREF), .OFF_W(OFF_W)) u_tap (
        .main_i(main_arr), .off_i(off), .neg_i(neg), .pos_o(pos),
        .p0_o(t0), .p1_o(t1), .p2_o(t2), .p3_o(t3)
    );

    // Round the phase to one of 17 filters and add the family base.
    always_comb begin
        fsel     = FILT_W'(({1'b0, phase} + 1'b1) >> 1);
        filt_nxt = size_is_smooth(size_i) ? fsel + FILT_W'(FAM_SPAN) : fsel;
    end

    // Output register stage; data loads only on an accepted position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            p0_o    <= '0;
            p1_o    <= '0;
            p2_o    <= '0;
            p3_o    <= '0;
            filt_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                p0_o   <= t0;
                p1_o   <= t1;
                p2_o   <= t2;
                p3_o   <= t3;
                filt_o <= filt_nxt;
            end
        end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && $stable(filt_o) && $stable(p1_o)));
    // R7
    smooth_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && size_i[1]) |=> (filt_o >= FILT_W'(FAM_SPAN) && filt_o <= FILT_W'(2*FAM_SPAN-1)));
    // R7
    sharp_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !size_i[1]) |=> (filt_o < FILT_W'(FAM_SPAN)));
    // R3
    neg_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && angle_i[ANG_W-1]) |-> off[OFF_W-1]);
    // R3
    pos_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !angle_i[ANG_W-1]) |-> !off[OFF_W-1]);
    // R5
    low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pos == '0) |=> (p0_o == p1_o));
endmodule

// File: tb/ira_ref_selector_tb.sv
module ira_ref_selector_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW    = 8;
    localparam int NREF  = 34;
    localparam int IDX_W = 5;
    localparam int ANG_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_i = 1'b0;
    logic [6:0] mode_i = '0;
    logic [ANG_W-1:0] angle_i = '0;
    logic [IDX_W-1:0] idx_i = '0;
    logic [1:0] size_i = '0;
    logic [NREF*SW-1:0] above_i;
    logic [NREF*SW-1:0] left_i;
    logic valid_o;
    logic [SW-1:0] p0_o, p1_o, p2_o, p3_o;
    logic [5:0] filt_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ira_ref_selector #(.SW(SW), .NREF(NREF), .IDX_W(IDX_W), .ANG_W(ANG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
        .angle_i(angle_i), .idx_i(idx_i), .size_i(size_i),
        .above_i(above_i), .left_i(left_i), .valid_o(valid_o),
        .p0_o(p0_o), .p1_o(p1_o), .p2_o(p2_o), .p3_o(p3_o), .filt_o(filt_o)
    );

    function automatic int aval(int k); return 128 + k; endfunction
    function automatic int lval(int k); return 16 + k;  endfunction

    // Main array entry j per R1/R2.
    function automatic int mref(int j, bit neg, bit up);
        if (neg && j < 4) return up ? lval(3 - j) : aval(3 - j);
        if (neg)          return up ? aval(j - 4) : lval(j - 4);
        return up ? aval(j) : lval(j);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (mode %0d angle %0d idx %0d size %0d)",
                     tag, act, exp, mode_i, $signed(angle_i), idx_i, size_i);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < NREF; k++) begin
            above_i[k*SW +: SW] = SW'(aval(k));
            left_i[k*SW +: SW]  = SW'(lval(k));
        end
    end

    initial begin
        int modes [4] = '{2, 33, 34, 66};
        // Reset with valid held high: outputs must stay cleared (R8).
        valid_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset valid", valid_o, 0);
        check("R8 reset p1", p1_o, 0);
        check("R8 reset filt", filt_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        valid_i = 1'b0;
        @(posedge clk); #1;
        check("R8 idle valid", valid_o, 0);

        foreach (modes[mi]) begin
            for (int a = -32; a <= 32; a++) begin
                for (int ix = 0; ix < 32; ix++) begin
                    int prod, off, ph, pos, e0, e1, e2, e3, fs, ef;
                    bit neg, up;
                    @(negedge clk);
                    valid_i = 1'b1;
                    mode_i  = 7'(modes[mi]);
                    angle_i = ANG_W'(a);
                    idx_i   = IDX_W'(ix);
                    size_i  = 2'((ix + a + mi) & 3);
                    up   = (modes[mi] >= 34);
                    neg  = (a < 0);
                    prod = (ix + 1) * a;
                    off  = prod >>> 5;          // R3 floor
                    ph   = prod & 31;
                    pos  = off + (neg ? 4 : 0);
                    if (pos < 0) pos = 0;       // R4 clamp
                    if (pos > NREF - 2) pos = NREF - 2;
                    e1 = mref(pos, neg, up);
                    e2 = mref(pos + 1, neg, up);
                    e0 = (pos == 0) ? e1 : mref(pos - 1, neg, up);
                    e3 = (pos == NREF - 2) ? e2 : mref(pos + 2, neg, up);
                    fs = (ph + 1) >> 1;
                    ef = (size_i >= 2) ? 17 + fs : fs;
                    @(posedge clk); #1;
                    check("R8 valid", valid_o, 1);
                    check(neg ? "R2 R4 p1" : "R1 R3 R4 p1", p1_o, e1);
                    check(neg ? "R2 R4 p2" : "R1 R4 p2", p2_o, e2);
                    check("R5 p0", p0_o, e0);
                    check("R6 p3", p3_o, e3);
                    check("R7 filt", filt_o, ef);
                end
            end
        end

        // Hold check: valid low must drop valid_o and keep data (R8).
        begin
            int h1, hf;
            h1 = p1_o; hf = filt_o;
            @(negedge clk);
            valid_i = 1'b0;
            angle_i = ANG_W'(-5);
            idx_i   = '0;
            @(posedge clk); #1;
            check("R8 hold valid", valid_o, 0);
            check("R8 hold p1", p1_o, h1);
            check("R8 hold filt", filt_o, hf);
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule